// File: doc/BRIEF.md
# Event Buffer with Dual-Edge Serial Readout

The block keeps up to four digitized channel events and sends them out as serial frames at double data rate. An event is a channel address with a 10-bit amplitude and a 10-bit time value. A producer hands events over with a valid/ready handshake. While that happens, the serializer sends out earlier events.

The output uses two lanes, and both lanes change on both phases of the clock. With a 200 MHz clock each lane carries 400 Mbps, for 800 Mbps in total. A frame marker flags the first bit pair of every event. The buffer never drops an event silently: a write offered while the buffer is full stays pending and counts as an overflow attempt.

Top module: `evbuf_ddr_tx`

## Requirements
- R1: The buffer holds at most DEPTH (4) events. `wr_ready` and `buf_empty` follow the stored count: `wr_ready` is high exactly when fewer than 4 events are stored, and `buf_full` is its inverse. `buf_empty` is high exactly when none is stored. A word that is being shifted out is no longer stored.
- R2: A write and the removal of an event for sending may happen on the same clock edge. The stored count is then unchanged and no event is lost or reordered.
- R3: An event is packed as W = {channel[5:0], amplitude[9:0], time[9:0]} (26 bits). Two zero bits follow it to give the frame F[27:0] = {W, 2'b00}, and events leave in write order.
- R4: A frame takes 7 clock cycles, in bit pairs p = 0..13. Pair p puts F[27-2p] on `lane_odd` and F[26-2p] on `lane_even`. Pair 2c appears while the clock is high in cycle c of the frame, and pair 2c+1 appears while the clock is low.
- R5: `frame_mark` is high only during the high phase of the first cycle of each frame. At all other times it is low.
- R6: When no frame is being sent, both lanes and `frame_mark` are low.
- R7: A frame is always sent in full before the next event is taken. If an event is already stored when a frame ends, the next frame starts in the cycle right after the last cycle of that frame.
- R8: An event written at clock edge E, with no event waiting ahead of it, starts its frame in the cycle that begins at edge E+1, and no earlier.
- R9: `ovf_count` increases by one on every edge at which `wr_valid` is high and `wr_ready` is low. It stops at all ones and otherwise keeps its value.
- R10: After reset the buffer is empty, `wr_ready` is high, `ovf_count` is zero, and the lanes and marker are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both phases carry output data |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers an event |
| wr_ready | output | 1 | Buffer can accept an event |
| wr_chan | input | 6 | Channel address of the event |
| wr_amp | input | 10 | Amplitude of the event |
| wr_time | input | 10 | Time value of the event |
| lane_odd | output | 1 | Serial lane carrying odd-indexed frame bits |
| lane_even | output | 1 | Serial lane carrying even-indexed frame bits |
| frame_mark | output | 1 | High during the first bit pair of a frame |
| buf_full | output | 1 | All entries stored |
| buf_empty | output | 1 | No entry stored |
| ovf_count | output | OVF_W (8) | Saturating count of writes refused while full |

## Verification
The bench builds the block with its default depth and field widths and reduces OVF_W to 4. At that width, the many refused cycles of a long back-to-back stream drive the overflow counter into saturation. A sweep over all 64 channel addresses with computed amplitude and time patterns keeps the buffer full for long stretches, so full, simultaneous write/read and back-to-back framing occur again and again. Isolated writes into an idle buffer cover the start latency and the idle lanes.

// File: rtl/evbuf_ddr_tx.sv
module evbuf_ddr_tx #(
  parameter int DEPTH = 4,
  parameter int CH_W  = 6,
  parameter int AMP_W = 10,
  parameter int TIM_W = 10,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [AMP_W-1:0] wr_amp,
  input  logic [TIM_W-1:0] wr_time,
  output logic             lane_odd,
  output logic             lane_even,
  output logic             frame_mark,
  output logic             buf_full,
  output logic             buf_empty,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int WORD_W = CH_W + AMP_W + TIM_W;
  localparam int FR_W   = ((WORD_W + 3) / 4) * 4;
  localparam int NCYC   = FR_W / 4;
  localparam int CW     = $clog2(NCYC);
  localparam int PW     = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic [FR_W-1:0]   sh;
  logic [CW-1:0]     phase;
  logic              busy;
  logic [3:0]        slot;
  logic              frm;

  wire acc = wr_valid && wr_ready;
  wire pop = (cnt != '0) && (!busy || phase == CW'(NCYC - 1));
  wire [FR_W-1:0] nxt = FR_W'(mem[rp]) << (FR_W - WORD_W);

  assign wr_ready   = cnt != CNT_W'(DEPTH);
  assign buf_full   = !wr_ready;
  assign buf_empty  = cnt == '0;
  assign lane_odd   = clk ? slot[3] : slot[1];
  assign lane_even  = clk ? slot[2] : slot[0];
  assign frame_mark = clk & frm;

  always_ff @(posedge clk)
    if (acc) mem[wp] <= {wr_chan, wr_amp, wr_time};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      ovf_count <= '0;
    end else begin
      if (acc) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(acc) - CNT_W'(pop);
      if (wr_valid && !wr_ready && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      phase <= '0;
      busy <= 1'b0;
      slot <= '0;
      frm <= 1'b0;
    end else if (pop) begin
      slot <= nxt[FR_W-1 -: 4];
      sh <= nxt << 4;
      frm <= 1'b1;
      busy <= 1'b1;
      phase <= '0;
    end else if (busy && phase != CW'(NCYC - 1)) begin
      slot <= sh[FR_W-1 -: 4];
      sh <= sh << 4;
      frm <= 1'b0;
      phase <= phase + 1'b1;
    end else begin
      slot <= '0;
      frm <= 1'b0;
      busy <= 1'b0;
      phase <= '0;
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(DEPTH));
  p_full_refuses_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH) && !pop) |=> cnt == CNT_W'(DEPTH));
  p_same_edge_r2: assert property (@(posedge clk) disable iff (!rst_n) (acc && pop) |=> $stable(cnt));
  p_mark_once_r5: assert property (@(posedge clk) disable iff (!rst_n) frm |=> !frm);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (slot == 4'b0 && !frm));
  p_no_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != CW'(NCYC - 1)) |=> (busy && !frm && phase == $past(phase) + 1'b1));
  p_ovf_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && ovf_count != '1) |=> ovf_count == $past(ovf_count) + 1'b1);
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && !wr_ready) |=> $stable(ovf_count));
endmodule

// File: tb/evbuf_ddr_tx_tb_top.sv
module evbuf_ddr_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int OVF_W = 4;
  localparam int FRB = 28;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [5:0] wr_chan = '0;
  logic [9:0] wr_amp = '0, wr_time = '0;
  logic wr_ready, lane_odd, lane_even, frame_mark, buf_full, buf_empty;
  logic [OVF_W-1:0] ovf_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  evbuf_ddr_tx #(.DEPTH(DEPTH), .OVF_W(OVF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_amp(wr_amp), .wr_time(wr_time),
    .lane_odd(lane_odd), .lane_even(lane_even), .frame_mark(frame_mark),
    .buf_full(buf_full), .buf_empty(buf_empty), .ovf_count(ovf_count));

  int vectors = 0, errors = 0;
  int cyc_n = 0, pushed = 0, started = 0, nb = 0, end_cyc = 0;
  int ovf_exp = 0;
  bit collecting = 0, pending = 0, done = 0;
  logic [FRB-1:0] fr;
  logic [FRB-1:0] exp_q[$];
  int acc_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc_n);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > LIMIT && !done) begin
      done = 1;
      chk(0, "watchdog", cyc_n, LIMIT);
      finish_run();
    end
    #2;
    if (rst_n) begin
      if (frame_mark) begin
        chk(nb == 0, "R7 frame cut short", nb, 0);
        if (pending) chk(cyc_n == end_cyc + 1, "R7 back-to-back start", cyc_n, end_cyc + 1);
        else if (acc_q.size() > started)
          chk(cyc_n == acc_q[started] + 1, "R8 start latency", cyc_n, acc_q[started] + 1);
        started++;
        collecting = 1;
        nb = 0;
      end
      if (collecting) begin
        fr[FRB-1-nb] = lane_odd;
        fr[FRB-2-nb] = lane_even;
        nb += 2;
      end else chk({lane_odd, lane_even} == 2'b00, "R6 idle high phase", {lane_odd, lane_even}, 0);
    end
    #5;
    if (rst_n) begin
      chk(frame_mark == 1'b0, "R5 marker in low phase", frame_mark, 0);
      if (collecting) begin
        fr[FRB-1-nb] = lane_odd;
        fr[FRB-2-nb] = lane_even;
        nb += 2;
        if (nb == FRB) begin
          if (exp_q.size() == 0) chk(0, "R3 unexpected frame", fr, 0);
          else begin
            logic [FRB-1:0] e;
            e = exp_q.pop_front();
            chk(fr == e, "R3/R4 frame content", fr, e);
          end
          collecting = 0;
          nb = 0;
          end_cyc = cyc_n;
          pending = pushed > started;
        end
      end else chk({lane_odd, lane_even} == 2'b00, "R6 idle low phase", {lane_odd, lane_even}, 0);
    end
  end

  task automatic push(input logic [5:0] c, input logic [9:0] a, input logic [9:0] t);
    @(negedge clk); #1;
    wr_valid = 1'b1; wr_chan = c; wr_amp = a; wr_time = t;
    while (1) begin
      int occ;
      occ = pushed - started;
      chk(wr_ready == (occ < DEPTH), "R1 wr_ready vs occupancy", wr_ready, occ < DEPTH);
      chk(buf_full == (occ == DEPTH), "R1 buf_full", buf_full, occ == DEPTH);
      chk(buf_empty == (occ == 0), "R1 buf_empty", buf_empty, occ == 0);
      if (wr_ready) begin
        @(posedge clk); #1;
        acc_q.push_back(cyc_n);
        exp_q.push_back({c, a, t, 2'b00});
        pushed++;
        break;
      end
      @(posedge clk); #1;
      if (ovf_exp < (1 << OVF_W) - 1) ovf_exp++;
      chk(ovf_count == OVF_W'(ovf_exp), "R9 overflow count", ovf_count, ovf_exp);
      @(negedge clk); #1;
    end
  endtask

  task automatic idle_valid();
    @(negedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (started != pushed || collecting) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk(wr_ready == 1'b1, "R10 ready after reset", wr_ready, 1);
    chk(buf_empty == 1'b1, "R10 empty after reset", buf_empty, 1);
    chk(buf_full == 1'b0, "R10 not full after reset", buf_full, 0);
    chk(ovf_count == '0, "R10 overflow zero", ovf_count, 0);
    chk({lane_odd, lane_even, frame_mark} == 3'b000, "R10 lanes low", {lane_odd, lane_even, frame_mark}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8: isolated writes into an idle buffer, extreme values
    push(6'h3f, 10'h3ff, 10'h3ff); idle_valid(); drain();
    push(6'h00, 10'h000, 10'h000); idle_valid(); drain();
    push(6'h2a, 10'h155, 10'h2aa); idle_valid(); drain();

    // R1 R2 R7: burst that fills the buffer and overflows
    for (int i = 0; i < 7; i++) push(6'(i + 1), 10'(i * 100 + 3), 10'(900 - i * 77));
    idle_valid(); drain();

    // R9 saturation and R3 sweep over all channel addresses
    for (int i = 0; i < 64; i++) push(6'(i), 10'((i * 37 + 5) % 1024), 10'((1023 - i * 13) % 1024));
    idle_valid(); drain();

    chk(ovf_count == OVF_W'(ovf_exp), "R9 final overflow count", ovf_count, ovf_exp);
    chk(ovf_exp == (1 << OVF_W) - 1, "R9 saturation reached", ovf_exp, (1 << OVF_W) - 1);
    chk(exp_q.size() == 0, "R3 all frames delivered", exp_q.size(), 0);
    chk(buf_empty == 1'b1, "R1 empty after drain", buf_empty, 1);
    done = 1;
    finish_run();
  end
endmodule